// File: doc/BRIEF.md
# Microcontroller Reset Combiner and Controller

This block merges every reset request of a small microcontroller into one system reset. Eight request paths feed it: power-on, a supply fault, an external active-low reset pin, a watchdog expiry, a missing-clock alarm, a comparator low-level alarm, a software reset strobe and a conversion-start reset input. Power-on, the supply fault and the pin cannot be masked by software. The other five each have a software enable bit. Any request that is present and enabled pulls the system reset low in the same cycle. The reset then stays low for a fixed number of hold cycles after the last request ends.

While an internal request is active, the block pulls the bidirectional reset pin low. It blanks its own view of the pin while it does this, so it never triggers itself. During every reset it forces the clock select back to the internal oscillator and clears the software enables. A watchdog lock bit survives all resets except power-on. A cause register reports the highest-ranked source of the last reset and changes only when that reset ends.

Top module: `reset_funnel`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is 0, `rst_pin_drive` is 1, `clk_sel` is 0 and `en_rd` is 0. After `por_n` rises, `sys_rst_n` stays low for exactly HOLD_CYCLES rising edges. `cause` then reads 7.
- R2: When `mon_en` is 1 and `vdd_ok` is 0, `sys_rst_n` is 0. Release comes HOLD_CYCLES edges after `vdd_ok` returns, and `cause` then reads 6. When `mon_en` is 0, `vdd_ok` has no effect.
- R3: A low on `rst_pin_n` resets the system whatever the enables hold. It passes a 2-flop synchronizer, so release comes HOLD_CYCLES+2 edges after the pin returns high. `cause` then reads 5.
- R4: The enable bits in `cfg_wdata` are: [0] watchdog, [1] missing clock, [2] comparator, [3] software reset, [4] conversion-start reset. Each of these sources resets the system only when its bit is set and otherwise has no effect. The cause codes are watchdog 4, missing clock 3, comparator 2, software 1 and conversion-start 0.
- R5: `en_rd` is {lock, en[4:1], en[0] OR lock}. Every reset clears en[4:0]. Writing a 1 to `cfg_wdata[5]` sets the lock. Only `por_n` clears the lock, and while it is set the watchdog stays enabled.
- R6: A one-cycle pulse on a directly sampled source keeps `sys_rst_n` low for exactly HOLD_CYCLES edges after the pulse ends.
- R7: `rst_pin_drive` is 1 only while `sys_rst_n` is 0 and the reset came from a source other than the pin. A reset caused only by the pin leaves it at 0.
- R8: When several sources are active, `cause` takes the highest code (7 down to 0). It changes only on the edge that follows the release of reset, and it keeps its old value during the reset.
- R9: `clk_sel` (0 = internal, 1 = external) is forced to 0 during any reset. A write through `clksel_we` sets it while no reset is active.
- R10: A watchdog, comparator, software, conversion-start or supply request drives `sys_rst_n` low combinationally, in the cycle the request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| mon_en | input | 1 | Strap that enables the supply monitor |
| vdd_ok | input | 1 | Supply good flag from the monitor |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| clk_missing | input | 1 | Missing-clock alarm, asynchronous |
| cmp_low | input | 1 | Comparator low-level alarm |
| cnv_rst | input | 1 | Conversion-start reset request |
| rst_pin_n | input | 1 | Level read from the reset pin, asynchronous |
| sw_rst | input | 1 | One-cycle software reset strobe |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | 6 | Enable bits [4:0] and lock bit [5] |
| clksel_we | input | 1 | Write strobe for the clock select |
| clksel_wdata | input | 1 | New clock select value |
| sys_rst_n | output | 1 | System reset, active low |
| rst_pin_drive | output | 1 | Pull the reset pin low when 1 |
| clk_sel | output | 1 | Clock select, 0 means internal oscillator |
| en_rd | output | 6 | Enable and lock readback |
| cause | output | 3 | Code of the last reset cause |

## Verification
The hardest case to reach is the pin feedback loop. The block drives the pin low, and that low comes back through the synchronizer after the drive stops. The bench wires the pin as an open-drain line, shared by its own external pull and `rst_pin_drive`. Every internal reset therefore really loops back, and the bench checks that no extra reset follows. Two further cases need care: a lock set by software that must survive a watchdog reset, and two sources fired in the same cycle to check the ranking.

// File: rtl/rstc_pkg.sv
// Package: shared cause codes and enable bit positions for the reset combiner.
// Assumes: cause codes double as priority ranks (higher code wins).
package rstc_pkg;
    localparam int N_SRC   = 8;
    localparam int N_MASK  = 5;
    localparam int CFG_W   = N_MASK + 1;
    localparam int CAUSE_W = $clog2(N_SRC);

    typedef enum logic [CAUSE_W-1:0] {
        CZ_CNV    = 3'd0,
        CZ_SWR    = 3'd1,
        CZ_CMP    = 3'd2,
        CZ_MCLK   = 3'd3,
        CZ_WDT    = 3'd4,
        CZ_PIN    = 3'd5,
        CZ_SUPPLY = 3'd6,
        CZ_POR    = 3'd7
    } cause_e;

    localparam int EN_WDT  = 0;
    localparam int EN_MCLK = 1;
    localparam int EN_CMP  = 2;
    localparam int EN_SWR  = 3;
    localparam int EN_CNV  = 4;
    localparam int LOCK_BIT = 5;
endpackage

// File: rtl/rstc_sync.sv
// Module: multi-flop synchronizer for an asynchronous level input.
// Assumes: STAGES >= 2; RST_VAL is the inactive level of the input.
module rstc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {STAGES{RST_VAL}};
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/rstc_hold.sv
// Module: reset stretcher. Reloads while any request is present, counts
// down afterwards; reset is active while a request exists or count != 0.
// Assumes: HOLD_CYCLES >= 1; the power-on reset reloads the counter.
module rstc_hold #(
    parameter int HOLD_CYCLES = 1024
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_any,
    output logic active
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt;

    // Reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!por_n)               cnt <= LOAD;
        else if (req_any)         cnt <= LOAD;
        else if (cnt != '0)       cnt <= cnt - 1'b1;
    end

    assign active = req_any || (cnt != '0);
endmodule

// File: rtl/rstc_cause.sv
// Module: cause recorder. Tracks the highest-ranked request seen during
// one reset episode and publishes it when the reset is released.
// Assumes: req index equals cause code; power-on reset implies code 7.
module rstc_cause
    import rstc_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic [N_SRC-1:0] req,
    input  logic             active,
    output cause_e           cause
);
    cause_e cur;
    cause_e pend;
    logic   active_q;

    // Priority encode: highest set request index wins.
    always_comb begin
        cur = CZ_CNV;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i]) cur = cause_e'(3'(i));
        end
    end

    // Track the episode's top cause and publish it on release.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            pend     <= CZ_POR;
            cause    <= CZ_POR;
            active_q <= 1'b1;
        end else begin
            active_q <= active;
            if (|req && (!active_q || cur > pend)) pend <= cur;
            if (active_q && !active)              cause <= pend;
        end
    end
endmodule

// File: rtl/reset_funnel.sv
// Module: top of the reset combiner. Gathers requests, applies software
// enables, stretches the reset, drives the reset pin, forces the clock
// select to internal and records the reset cause.
// Assumes: wdt_expire, cmp_low, cnv_rst, sw_rst, vdd_ok and mon_en are
// synchronous to clk; rst_pin_n and clk_missing are asynchronous.
module reset_funnel
    import rstc_pkg::*;
#(
    parameter int HOLD_CYCLES = 1024,
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_CYCLES = 3
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               mon_en,
    input  logic               vdd_ok,
    input  logic               wdt_expire,
    input  logic               clk_missing,
    input  logic               cmp_low,
    input  logic               cnv_rst,
    input  logic               rst_pin_n,
    input  logic               sw_rst,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               clksel_we,
    input  logic               clksel_wdata,
    output logic               sys_rst_n,
    output logic               rst_pin_drive,
    output logic               clk_sel,
    output logic [CFG_W-1:0]   en_rd,
    output logic [CAUSE_W-1:0] cause
);
    localparam int BW = $clog2(BLANK_CYCLES + 1);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYCLES);

    logic              pin_s, mclk_s;
    logic [N_MASK-1:0] en;
    logic              wdt_lock;
    logic [N_SRC-1:0]  req;
    logic              int_any, active, drive_q;
    logic [BW-1:0]     blank;
    cause_e            cause_q;

    rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(por_n), .d(rst_pin_n), .q(pin_s));

    rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mclk_sync (
        .clk(clk), .rst_n(por_n), .d(clk_missing), .q(mclk_s));

    // Gather the gated requests, indexed by cause code.
    always_comb begin
        req            = '0;
        req[CZ_POR]    = !por_n;
        req[CZ_SUPPLY] = mon_en && !vdd_ok;
        req[CZ_PIN]    = !pin_s && !drive_q && (blank == '0);
        req[CZ_WDT]    = wdt_expire && (en[EN_WDT] || wdt_lock);
        req[CZ_MCLK]   = mclk_s && en[EN_MCLK];
        req[CZ_CMP]    = cmp_low && en[EN_CMP];
        req[CZ_SWR]    = sw_rst && en[EN_SWR];
        req[CZ_CNV]    = cnv_rst && en[EN_CNV];
        int_any        = |(req & ~(N_SRC'(1) << CZ_PIN));
    end

    rstc_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .por_n(por_n), .req_any(|req), .active(active));

    rstc_cause u_cause (
        .clk(clk), .por_n(por_n), .req(req), .active(active), .cause(cause_q));

    // Software enables: cleared by any reset, written otherwise.
    always_ff @(posedge clk) begin
        if (!por_n || active) en <= '0;
        else if (cfg_we)      en <= cfg_wdata[N_MASK-1:0];
    end

    // Watchdog lock: set by software, cleared only by power-on.
    always_ff @(posedge clk) begin
        if (!por_n)                                   wdt_lock <= 1'b0;
        else if (cfg_we && cfg_wdata[LOCK_BIT] && !active) wdt_lock <= 1'b1;
    end

    // Pin drive flag: set by internal requests, dropped on release.
    always_ff @(posedge clk) begin
        if (!por_n)       drive_q <= 1'b1;
        else if (int_any) drive_q <= 1'b1;
        else if (!active) drive_q <= 1'b0;
    end

    // Blank the pin input while our own drive echoes through the synchronizer.
    always_ff @(posedge clk) begin
        if (!por_n)           blank <= BLANK_LOAD;
        else if (drive_q)     blank <= BLANK_LOAD;
        else if (blank != '0) blank <= blank - 1'b1;
    end

    // Clock select: internal during reset, software choice otherwise.
    always_ff @(posedge clk) begin
        if (!por_n || active) clk_sel <= 1'b0;
        else if (clksel_we)   clk_sel <= clksel_wdata;
    end

    assign sys_rst_n     = !active;
    assign rst_pin_drive = active && (drive_q || int_any);
    assign en_rd         = {wdt_lock, en[N_MASK-1:1], en[EN_WDT] | wdt_lock};
    assign cause         = cause_q;
endmodule

// File: rtl/reset_funnel_chk.sv
// Module: property checker for reset_funnel, attached with bind.
// Assumes: observes top-level ports only.
module reset_funnel_chk (
    input logic       clk,
    input logic       por_n,
    input logic       mon_en,
    input logic       vdd_ok,
    input logic       sys_rst_n,
    input logic       rst_pin_drive,
    input logic       clk_sel,
    input logic [5:0] en_rd,
    input logic [2:0] cause
);
    // R2: an enabled supply fault always holds the system in reset.
    assert_supply_holds_R2: assert property (@(posedge clk) disable iff (!por_n)
        (mon_en && !vdd_ok) |-> !sys_rst_n);

    // R5: the lock bit never clears without power-on.
    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!por_n)
        en_rd[5] |=> en_rd[5]);

    // R5: maskable enables are cleared after a reset cycle.
    assert_enables_cleared_R5: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> (en_rd[4:1] == 4'd0));

    // R7: the pin is only pulled while the system is in reset.
    assert_pin_drive_in_reset_R7: assert property (@(posedge clk) disable iff (!por_n)
        rst_pin_drive |-> !sys_rst_n);

    // R8: the cause changes only right after a release.
    assert_cause_on_release_R8: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(cause) |-> ($past(sys_rst_n) && !$past(sys_rst_n, 2)));

    // R9: any reset returns the clock select to internal.
    assert_clksel_internal_R9: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> !clk_sel);
endmodule

bind reset_funnel reset_funnel_chk u_chk (
    .clk(clk), .por_n(por_n), .mon_en(mon_en), .vdd_ok(vdd_ok),
    .sys_rst_n(sys_rst_n), .rst_pin_drive(rst_pin_drive), .clk_sel(clk_sel),
    .en_rd(en_rd), .cause(cause));

// File: tb/tb_reset_funnel.sv
// Bench: vector table for the maskable sources, then directed tests.
module tb_reset_funnel;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, mon_en = 1'b1, vdd_ok = 1'b1;
    logic       wdt_expire = 1'b0, clk_missing = 1'b0, cmp_low = 1'b0;
    logic       cnv_rst = 1'b0, sw_rst = 1'b0, ext_low = 1'b0;
    logic       cfg_we = 1'b0, clksel_we = 1'b0, clksel_wdata = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       sys_rst_n, rst_pin_drive, clk_sel;
    logic [5:0] en_rd;
    logic [2:0] cause;
    logic       pin_line;
    int         n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    // Open-drain pin: pulled low by the outside world or by the block.
    assign pin_line = (ext_low || rst_pin_drive) ? 1'b0 : 1'b1;

    reset_funnel #(.HOLD_CYCLES(H)) dut (
        .clk(clk), .por_n(por_n), .mon_en(mon_en), .vdd_ok(vdd_ok),
        .wdt_expire(wdt_expire), .clk_missing(clk_missing), .cmp_low(cmp_low),
        .cnv_rst(cnv_rst), .rst_pin_n(pin_line), .sw_rst(sw_rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clksel_we(clksel_we),
        .clksel_wdata(clksel_wdata), .sys_rst_n(sys_rst_n),
        .rst_pin_drive(rst_pin_drive), .clk_sel(clk_sel), .en_rd(en_rd),
        .cause(cause));

    // {enables[4:0], source[2:0], expect_reset, expect_cause[2:0]}
    // source: 0 wdt, 1 missing clock, 2 comparator, 3 software, 4 conversion
    localparam logic [11:0] VEC [10] = '{
        {5'b00001, 3'd0, 1'b1, 3'd4}, {5'b11110, 3'd0, 1'b0, 3'd0},
        {5'b00010, 3'd1, 1'b1, 3'd3}, {5'b11101, 3'd1, 1'b0, 3'd0},
        {5'b00100, 3'd2, 1'b1, 3'd2}, {5'b11011, 3'd2, 1'b0, 3'd0},
        {5'b01000, 3'd3, 1'b1, 3'd1}, {5'b10111, 3'd3, 1'b0, 3'd0},
        {5'b10000, 3'd4, 1'b1, 3'd0}, {5'b01111, 3'd4, 1'b0, 3'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Count rising edges until sys_rst_n is seen high at a falling edge.
    task automatic wait_release(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!sys_rst_n && n < 200);
    endtask

    task automatic cfg_write(input logic [5:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_src(input int s);
        @(negedge clk);
        case (s)
            0: wdt_expire = 1'b1;
            1: clk_missing = 1'b1;
            2: cmp_low = 1'b1;
            3: sw_rst = 1'b1;
            default: cnv_rst = 1'b1;
        endcase
        @(negedge clk);
        {wdt_expire, clk_missing, cmp_low, sw_rst, cnv_rst} = '0;
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        begin int n; wait_release(n); end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int n;
        logic [2:0] prev;
        // R1: state while power-on reset is held, then exact release length.
        repeat (3) @(negedge clk);
        chk(sys_rst_n == 1'b0, "R1 sys_rst_n in por", sys_rst_n, 0);
        chk(rst_pin_drive == 1'b1, "R1 pin drive in por", rst_pin_drive, 1);
        chk(clk_sel == 1'b0 && en_rd == 6'd0, "R1 clk_sel/en_rd in por", {clk_sel, en_rd}, 0);
        por_n = 1'b1;
        wait_release(n);
        chk(n == H, "R1 por stretch", n, H);
        @(posedge clk); @(negedge clk);
        chk(cause == 3'd7, "R1 por cause", cause, 7);
        chk(rst_pin_drive == 1'b0, "R7 pin released", rst_pin_drive, 0);
        repeat (5) @(negedge clk);
        chk(sys_rst_n == 1'b1, "R7 no self-trigger after drive", sys_rst_n, 1);

        // R4/R5: table of maskable sources with enable patterns.
        for (int i = 0; i < 10; i++) begin
            logic [4:0] en_v;
            int src;
            bit saw;
            en_v = VEC[i][11:7];
            src  = int'(VEC[i][6:4]);
            cfg_write({1'b0, en_v});
            chk(en_rd == {1'b0, en_v}, "R5 enable readback", en_rd, {1'b0, en_v});
            pulse_src(src);
            saw = 1'b0;
            for (int k = 0; k < 6; k++) begin
                if (!sys_rst_n) saw = 1'b1;
                @(negedge clk);
            end
            chk(saw == VEC[i][3], "R4 source gating", saw, VEC[i][3]);
            if (VEC[i][3]) begin
                wait_release(n);
                @(posedge clk); @(negedge clk);
                chk(cause == VEC[i][2:0], "R4 cause code", cause, VEC[i][2:0]);
                chk(en_rd[4:0] == 5'd0, "R5 enables cleared", en_rd[4:0], 0);
            end else begin
                chk(en_rd[4:0] == en_v, "R4 ignored source keeps enables", en_rd[4:0], en_v);
            end
            repeat (4) @(negedge clk);
        end

        // R10/R6: combinational assertion and exact stretch of one pulse.
        cfg_write(6'b000100);
        @(negedge clk); cmp_low = 1'b1; #1;
        chk(sys_rst_n == 1'b0, "R10 same-cycle assert", sys_rst_n, 0);
        chk(rst_pin_drive == 1'b1, "R7 drive on internal", rst_pin_drive, 1);
        @(negedge clk); cmp_low = 1'b0;
        wait_release(n);
        chk(n == H, "R6 pulse stretch", n, H);
        repeat (6) @(negedge clk);
        chk(sys_rst_n == 1'b1, "R7 pin echo blanked", sys_rst_n, 1);

        // R2: supply fault with strap enabled, then ignored with strap off.
        @(negedge clk); vdd_ok = 1'b0; #1;
        chk(sys_rst_n == 1'b0, "R2 supply assert", sys_rst_n, 0);
        repeat (5) @(negedge clk);
        vdd_ok = 1'b1;
        wait_release(n);
        chk(n == H, "R2 supply stretch", n, H);
        @(posedge clk); @(negedge clk);
        chk(cause == 3'd6, "R2 supply cause", cause, 6);
        repeat (6) @(negedge clk);
        mon_en = 1'b0; vdd_ok = 1'b0;
        repeat (10) @(negedge clk);
        chk(sys_rst_n == 1'b1, "R2 strap off ignores fault", sys_rst_n, 1);
        vdd_ok = 1'b1; mon_en = 1'b1;

        // R3/R7: external pin reset, unmaskable, no drive from the block.
        @(negedge clk); ext_low = 1'b1;
        repeat (5) @(negedge clk);
        chk(sys_rst_n == 1'b0, "R3 pin reset", sys_rst_n, 0);
        chk(rst_pin_drive == 1'b0, "R7 no drive on pin reset", rst_pin_drive, 0);
        ext_low = 1'b0;
        wait_release(n);
        chk(n == H + 2, "R3 pin stretch", n, H + 2);
        @(posedge clk); @(negedge clk);
        chk(cause == 3'd5, "R3 pin cause", cause, 5);

        // R5: lock set, cannot be cleared, survives a watchdog reset.
        cfg_write(6'b100000);
        chk(en_rd == 6'b100001, "R5 lock set", en_rd, 6'b100001);
        cfg_write(6'b000000);
        chk(en_rd == 6'b100001, "R5 lock write-proof", en_rd, 6'b100001);
        pulse_src(0);
        wait_release(n);
        @(posedge clk); @(negedge clk);
        chk(cause == 3'd4, "R5 locked watchdog fires", cause, 4);
        chk(en_rd == 6'b100001, "R5 lock survives reset", en_rd, 6'b100001);
        do_por();
        chk(en_rd == 6'b000000, "R5 por clears lock", en_rd, 0);

        // R9: clock select written, then forced back by a reset.
        @(negedge clk); clksel_we = 1'b1; clksel_wdata = 1'b1;
        @(negedge clk); clksel_we = 1'b0;
        chk(clk_sel == 1'b1, "R9 switch to external", clk_sel, 1);
        cfg_write(6'b001000);
        pulse_src(3);
        chk(clk_sel == 1'b0, "R9 forced internal", clk_sel, 0);
        wait_release(n);
        chk(clk_sel == 1'b0, "R9 internal after reset", clk_sel, 0);

        // R8: two sources together; cause keeps old value during reset.
        repeat (4) @(negedge clk);
        prev = cause;
        cfg_write(6'b000101);
        @(negedge clk); wdt_expire = 1'b1; cmp_low = 1'b1;
        @(negedge clk); wdt_expire = 1'b0; cmp_low = 1'b0;
        repeat (3) @(negedge clk);
        chk(cause == prev, "R8 cause held during reset", cause, prev);
        wait_release(n);
        @(posedge clk); @(negedge clk);
        chk(cause == 3'd4, "R8 priority wdt over cmp", cause, 4);

        summary();
    end
endmodule